// File: doc/BRIEF.md
# Timer Interrupt Flag Register

This block holds the four interrupt flags of an 8-bit timer/counter: input capture, compare-match B, compare-match A and overflow. The counter, the waveform logic and the capture edge detector sit outside it. They reach it as inputs: the counter value, both compare values, the capture register value, a capture event pulse, an overflow pulse and a timer tick enable. A flag is raised by timer events, but only on ticks. It is lowered either by the processor writing a one to its bit or by the interrupt controller acknowledging its vector.

The flags read back as one status byte. Each flag also drives an interrupt request line, gated by an external enable. A compare flag rises one tick after the counter equals its compare value, so that the flag lines up with the output change. Forced-compare strobes never touch the flags. When the capture register serves as the counter TOP, the capture flag marks the counter reaching TOP rather than a pin event.

Top module: `tmr_irq_flags`

## Requirements
- R1: Status byte layout: capture flag at bit 5, compare-B flag at bit 2, compare-A flag at bit 1, overflow flag at bit 0. Bits 7, 6, 4 and 3 always read 0. All flags are 0 after reset.
- R2: When `tick_i` is high on an edge with `count_i` equal to a compare value, the matching compare flag is not set on that edge. It is set on the next edge with `tick_i` high.
- R3: `force_a_i` and `force_b_i` never set a compare flag.
- R4: With `top_is_cap_i` low, the capture flag is set on a tick edge with `cap_evt_i` high. With `top_is_cap_i` high, it is set on a tick edge where `count_i` equals `cap_top_i`, and `cap_evt_i` is ignored.
- R5: The overflow flag is set on a tick edge with `ovf_i` high.
- R6: An acknowledge pulse on `ack_i` clears the flag of the same index (3 capture, 2 compare-B, 1 compare-A, 0 overflow).
- R7: A write with `wr_en_i` clears each flag whose status bit position in `wr_data_i` is one. Zero bits leave their flags unchanged. Writes to the unused bits have no effect.
- R8: If a flag's set condition and a clear (write-one or acknowledge) occur on the same edge, the flag ends set.
- R9: `irq_o[i]` is high exactly when the flag of index i (same order as `ack_i`) is set and `irq_en_i[i]` is high.
- R10: Set conditions act only on edges with `tick_i` high. Clears act on every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Timer clock enable |
| count_i | input | CNT_W | Counter value |
| cmp_a_i | input | CNT_W | Compare value A |
| cmp_b_i | input | CNT_W | Compare value B |
| cap_top_i | input | CNT_W | Capture register value, used as TOP in that mode |
| cap_evt_i | input | 1 | Capture event pulse |
| top_is_cap_i | input | 1 | Capture register selected as TOP |
| ovf_i | input | 1 | Counter overflow pulse |
| force_a_i | input | 1 | Forced compare strobe A |
| force_b_i | input | 1 | Forced compare strobe B |
| ack_i | input | 4 | Interrupt acknowledge pulses {cap, B, A, ovf} |
| wr_en_i | input | 1 | Status register write strobe |
| wr_data_i | input | 8 | Write data, ones clear flags |
| irq_en_i | input | 4 | Interrupt enables {cap, B, A, ovf} |
| status_o | output | 8 | Status byte |
| irq_o | output | 4 | Interrupt requests {cap, B, A, ovf} |

## Verification
The bench drives random cycles with a small counter range, so that matches against the compare and capture values are frequent. Every cycle is compared bit by bit with a bench model. This tells a compare flag that rises one tick late from one that rises on the match itself. It also tells tick-gated sets from ungated ones. Directed sequences cover the rest: strobes with no match (forced compare is ignored), a pin event against a TOP hit in both capture modes, and a set and a clear on the same edge (set wins). Writes of zero, of single ones and of the unused bits show that only the selected flag clears.

// File: rtl/tmr_irq_flags.sv
module tmr_irq_flags #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic [CNT_W-1:0] cmp_a_i,
  input  logic [CNT_W-1:0] cmp_b_i,
  input  logic [CNT_W-1:0] cap_top_i,
  input  logic             cap_evt_i,
  input  logic             top_is_cap_i,
  input  logic             ovf_i,
  input  logic             force_a_i,
  input  logic             force_b_i,
  input  logic [3:0]       ack_i,
  input  logic             wr_en_i,
  input  logic [7:0]       wr_data_i,
  input  logic [3:0]       irq_en_i,
  output logic [7:0]       status_o,
  output logic [3:0]       irq_o
);
  localparam int BIT_CAP = 5;
  localparam int BIT_B   = 2;
  localparam int BIT_A   = 1;
  localparam int BIT_OVF = 0;

  logic [3:0] flags_q, flag_set, flag_clr;
  logic       hit_a_q, hit_b_q;
  logic       cap_cond;
  logic       unused_force;

  assign unused_force = force_a_i | force_b_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      hit_a_q <= 1'b0;
      hit_b_q <= 1'b0;
    end else if (tick_i) begin
      hit_a_q <= (count_i == cmp_a_i);
      hit_b_q <= (count_i == cmp_b_i);
    end
  end

  assign cap_cond = top_is_cap_i ? (count_i == cap_top_i) : cap_evt_i;

  assign flag_set = {4{tick_i}} & {cap_cond, hit_b_q, hit_a_q, ovf_i};

  assign flag_clr = ack_i | ({4{wr_en_i}} &
                    {wr_data_i[BIT_CAP], wr_data_i[BIT_B], wr_data_i[BIT_A], wr_data_i[BIT_OVF]});

  always_ff @(posedge clk_i) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= (flags_q & ~flag_clr) | flag_set;
  end

  always_comb begin
    status_o          = '0;
    status_o[BIT_CAP] = flags_q[3];
    status_o[BIT_B]   = flags_q[2];
    status_o[BIT_A]   = flags_q[1];
    status_o[BIT_OVF] = flags_q[0];
  end

  assign irq_o = flags_q & irq_en_i;
endmodule

// File: rtl/tmr_irq_flags_chk.sv
module tmr_irq_flags_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tick_i,
  input logic [CNT_W-1:0] count_i,
  input logic [CNT_W-1:0] cmp_a_i,
  input logic [CNT_W-1:0] cap_top_i,
  input logic             cap_evt_i,
  input logic             top_is_cap_i,
  input logic             ovf_i,
  input logic [3:0]       ack_i,
  input logic             wr_en_i,
  input logic [7:0]       wr_data_i,
  input logic [3:0]       irq_en_i,
  input logic [7:0]       status_o,
  input logic [3:0]       irq_o
);
  logic seen_a;
  always_ff @(posedge clk_i) begin
    if (!rst_ni)     seen_a <= 1'b0;
    else if (tick_i) seen_a <= (count_i == cmp_a_i);
  end

  p_unused_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (status_o[7:6] == 2'b00 && status_o[4:3] == 2'b00));

  p_cmpa_late_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && seen_a) |=> status_o[1]);

  p_cmpa_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!status_o[1] && !(tick_i && seen_a)) |=> !status_o[1]);

  p_cap_top_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && top_is_cap_i && count_i == cap_top_i) |=> status_o[5]);

  p_cap_pin_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !top_is_cap_i && cap_evt_i) |=> status_o[5]);

  p_ovf_set_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && ovf_i) |=> status_o[0]);

  p_ack_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i[0] && !(tick_i && ovf_i)) |=> !status_o[0]);

  p_wr_clear_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_data_i[0] && !(tick_i && ovf_i)) |=> !status_o[0]);

  p_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ack_i[0] && !(wr_en_i && wr_data_i[0])) |=> $stable(status_o[0]));

  p_irq_gate_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o[0] |-> (irq_en_i[0] && status_o[0]));
endmodule

bind tmr_irq_flags tmr_irq_flags_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick_i), .count_i(count_i),
  .cmp_a_i(cmp_a_i), .cap_top_i(cap_top_i), .cap_evt_i(cap_evt_i),
  .top_is_cap_i(top_is_cap_i), .ovf_i(ovf_i), .ack_i(ack_i),
  .wr_en_i(wr_en_i), .wr_data_i(wr_data_i), .irq_en_i(irq_en_i),
  .status_o(status_o), .irq_o(irq_o)
);

// File: tb/test_tmr_irq_flags.sv
module test_tmr_irq_flags;
  localparam int W = 8;
  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 0, cap_evt = 0, top_cap = 0, ovf = 0, fa = 0, fb = 0, wr_en = 0;
  logic [W-1:0] cnt = 0, cmpa = 0, cmpb = 0, capt = 0;
  logic [3:0] ack = 0, irq_en = 0;
  logic [7:0] wdat = 0;
  logic [7:0] status;
  logic [3:0] irq;

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  logic [3:0] m_f = 0;
  logic m_ma = 0, m_mb = 0;

  always #2 clk = ~clk;

  tmr_irq_flags #(.CNT_W(W)) i_tmr_irq_flags (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .count_i(cnt), .cmp_a_i(cmpa),
    .cmp_b_i(cmpb), .cap_top_i(capt), .cap_evt_i(cap_evt), .top_is_cap_i(top_cap),
    .ovf_i(ovf), .force_a_i(fa), .force_b_i(fb), .ack_i(ack), .wr_en_i(wr_en),
    .wr_data_i(wdat), .irq_en_i(irq_en), .status_o(status), .irq_o(irq));

  function automatic logic [7:0] to_byte(logic [3:0] f);
    return {2'b00, f[3], 2'b00, f[2], f[1], f[0]};
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_step();
    logic [3:0] clr, set;
    clr = ack | (wr_en ? {wdat[5], wdat[2], wdat[1], wdat[0]} : 4'b0);
    set = {4{tick}} & {(top_cap ? (cnt == capt) : cap_evt), m_mb, m_ma, ovf};
    m_f = (m_f & ~clr) | set;
    if (tick) begin
      m_ma = (cnt == cmpa);
      m_mb = (cnt == cmpb);
    end
  endtask

  task automatic step();
    model_step();
    @(posedge clk); #1;
    chk("R5 overflow bit", {7'b0, status[0]}, {7'b0, m_f[0]});
    chk("R2 compare-A bit", {7'b0, status[1]}, {7'b0, m_f[1]});
    chk("R2 compare-B bit", {7'b0, status[2]}, {7'b0, m_f[2]});
    chk("R4 capture bit", {7'b0, status[5]}, {7'b0, m_f[3]});
    chk("R1 unused bits", {4'b0, status[7:6], status[4:3]}, 8'h00);
    chk("R9 irq lines", {4'b0, irq}, {4'b0, m_f & irq_en});
    @(negedge clk);
  endtask

  task automatic idle();
    tick = 0; cap_evt = 0; ovf = 0; fa = 0; fb = 0; ack = 0; wr_en = 0; wdat = 0;
  endtask

  task automatic clear_all();
    idle(); wr_en = 1; wdat = 8'hFF; step(); idle();
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 reset status", status, 8'h00);
    rst_n = 1;
    step();

    // R2: no set on match edge, gated by tick, set on next tick
    cmpa = 8'd3; cmpb = 8'd9; cnt = 8'd3; tick = 1; step();
    chk("R2 not on match edge", status & 8'h02, 8'h00);
    cnt = 8'd4; tick = 0; step();
    chk("R10 no set without tick", status & 8'h02, 8'h00);
    tick = 1; step();
    chk("R2 set on following tick", status & 8'h02, 8'h02);

    // R7: write zero keeps, write one clears only its bit
    tick = 1; ovf = 1; step(); idle();
    chk("R5 overflow set", status & 8'h01, 8'h01);
    wr_en = 1; wdat = 8'h00; step(); idle();
    chk("R7 write zero keeps", status, 8'h03);
    wr_en = 1; wdat = 8'hDA; step(); idle();
    chk("R7 unused/one write clears A only", status, 8'h01);

    // R6 acknowledge
    ack = 4'b0001; step(); idle();
    chk("R6 ack clears overflow", status, 8'h00);

    // R8 set wins over write and ack
    tick = 1; ovf = 1; wr_en = 1; wdat = 8'h01; ack = 4'b0001; step(); idle();
    chk("R8 set beats clear", status & 8'h01, 8'h01);
    clear_all();

    // R3 forced strobes alone
    cnt = 8'd7; cmpa = 8'd1; cmpb = 8'd2;
    for (int i = 0; i < 5; i++) begin tick = 1; fa = 1; fb = 1; step(); end
    idle();
    chk("R3 force ignored", status & 8'h06, 8'h00);

    // R4 capture modes
    top_cap = 1; capt = 8'd5; cnt = 8'd6; tick = 1; cap_evt = 1; step(); idle();
    chk("R4 pin ignored in TOP mode", status & 8'h20, 8'h00);
    cnt = 8'd5; tick = 1; step(); idle();
    chk("R4 TOP hit sets", status & 8'h20, 8'h20);
    clear_all();
    top_cap = 0; cnt = 8'd5; tick = 1; step(); idle();
    chk("R4 TOP ignored in pin mode", status & 8'h20, 8'h00);
    tick = 1; cap_evt = 1; step(); idle();
    chk("R4 pin event sets", status & 8'h20, 8'h20);

    // R9 enables
    irq_en = 4'b1000; step();
    chk("R9 enabled irq", {4'b0, irq}, 8'h08);
    irq_en = 4'b0111; step();
    chk("R9 disabled irq", {4'b0, irq}, 8'h00);
    clear_all();

    for (int i = 0; i < 3000; i++) begin
      tick = ($urandom % 3) != 0;
      cnt = W'($urandom % 6); cmpa = W'($urandom % 6); cmpb = W'($urandom % 6);
      capt = W'($urandom % 6);
      cap_evt = ($urandom % 5) == 0; top_cap = ($urandom % 4) == 0;
      ovf = ($urandom % 6) == 0; fa = $urandom % 2; fb = $urandom % 2;
      ack = 4'($urandom) & {4{($urandom % 4) == 0}};
      wr_en = ($urandom % 5) == 0; wdat = 8'($urandom);
      irq_en = 4'($urandom);
      step();
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule